// File: doc/BRIEF.md
# Dual register bank exchanger

This block is a small banked register file for a processor core. Its storage is four banks of six 8-bit registers each. The banks form two groups, A and B. Each group has a main bank and an alternate bank. At any moment the core sees exactly one bank of each group. An exchange request picks, independently for each group, whether the main or the alternate bank is visible. The deselected bank keeps its contents untouched and shows them again when it is reselected.

The same exchange request carries a 2-bit control for the core's global interrupt enable. The enable can be left alone, set or cleared. One code value is reserved: it is treated as "no change" and raises a one-cycle flag. There are two combinational read ports, one addressing the visible A bank and one addressing the visible B bank. A single write port carries a group select. Every access is steered to the bank that is active in that cycle. An exchange takes effect from the following cycle. A write in the same cycle as an exchange therefore lands in the bank that was active before it.

Top module: `regbank_xchg`

## Requirements
- R1: After reset both selectors are 0, meaning the main banks. The interrupt enable is 0, the reserved flag is 0, and every register in all four banks reads 0.
- R2: An exchange with A operand 0 makes main A visible and one with A operand 1 makes alternate A visible. This holds for reads and writes from the cycle after the exchange, and `sel_a` shows the operand from that cycle.
- R3: An exchange with B operand 0 makes main B visible and one with B operand 1 makes alternate B visible. This holds from the cycle after the exchange, and `sel_b` shows the operand.
- R4: The interrupt control code works as follows: code 0 leaves `int_en` unchanged, code 2 sets it to 1, and code 3 clears it to 0. The change is visible in the cycle after the exchange.
- R5: Code 1 leaves `int_en` unchanged and drives `reserved_flag` high for exactly the one cycle after that exchange. In every other cycle the flag is low.
- R6: A register in a deselected bank keeps its value while that bank is hidden and reads back unchanged once the bank is selected again.
- R7: A write goes to the active bank of the group named by `wr_grp` (0 for A, 1 for B) at the index `wr_idx`. When a write and an exchange happen in the same cycle, the write lands in the bank that was active before the exchange.
- R8: An index above 5 reads as 0 on either read port. A write to such an index changes no register.
- R9: While no exchange is requested, `sel_a`, `sel_b` and `int_en` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xchg_valid | input | 1 | Exchange request this cycle |
| xchg_sel_a | input | 1 | Group A operand: 0 main, 1 alternate |
| xchg_sel_b | input | 1 | Group B operand: 0 main, 1 alternate |
| xchg_ie_code | input | 2 | Interrupt control: 0 keep, 1 reserved, 2 set, 3 clear |
| wr_en | input | 1 | Register write strobe |
| wr_grp | input | 1 | Write group: 0 A, 1 B |
| wr_idx | input | 3 | Register index within the group |
| wr_data | input | 8 | Write data |
| rd_a_idx | input | 3 | Read index into visible A bank |
| rd_a_data | output | 8 | Read data from visible A bank |
| rd_b_idx | input | 3 | Read index into visible B bank |
| rd_b_data | output | 8 | Read data from visible B bank |
| sel_a | output | 1 | Current A selector |
| sel_b | output | 1 | Current B selector |
| int_en | output | 1 | Global interrupt enable |
| reserved_flag | output | 1 | One-cycle pulse after an exchange with code 1 |

## Verification
The assertions assume that the inputs are known, that is not X, at every rising edge outside reset. They also assume that a read index beyond the bank depth is a legal request, which must return zero rather than being excluded. The stimulus changes inputs only on falling edges and drives every input to a defined value from time zero. It deliberately sweeps indices 6 and 7, so the out-of-range paths are exercised within those assumptions.

// File: rtl/regbank_xchg.sv
module regbank_xchg #(
  parameter int DATA_W = 8,
  parameter int REGS   = 6,
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xchg_valid,
  input  logic              xchg_sel_a,
  input  logic              xchg_sel_b,
  input  logic [1:0]        xchg_ie_code,
  input  logic              wr_en,
  input  logic              wr_grp,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              sel_a,
  output logic              sel_b,
  output logic              int_en,
  output logic              reserved_flag
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGS - 1);

  logic [DATA_W-1:0] mem [4][REGS];
  logic [1:0] wr_bank, a_bank, b_bank;

  assign a_bank  = {1'b0, sel_a};
  assign b_bank  = {1'b1, sel_b};
  assign wr_bank = wr_grp ? b_bank : a_bank;

  assign rd_a_data = (rd_a_idx <= LAST_IDX) ? mem[a_bank][rd_a_idx] : '0;
  assign rd_b_data = (rd_b_idx <= LAST_IDX) ? mem[b_bank][rd_b_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < REGS; r++)
          mem[b][r] <= '0;
    end else if (wr_en && wr_idx <= LAST_IDX) begin
      mem[wr_bank][wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a         <= 1'b0;
      sel_b         <= 1'b0;
      int_en        <= 1'b0;
      reserved_flag <= 1'b0;
    end else begin
      reserved_flag <= xchg_valid && (xchg_ie_code == 2'd1);
      if (xchg_valid) begin
        sel_a <= xchg_sel_a;
        sel_b <= xchg_sel_b;
        case (xchg_ie_code)
          2'd2:    int_en <= 1'b1;
          2'd3:    int_en <= 1'b0;
          default: int_en <= int_en;
        endcase
      end
    end
  end

endmodule

module regbank_xchg_chk #(
  parameter int DATA_W = 8,
  parameter int REGS   = 6,
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xchg_valid,
  input logic              xchg_sel_a,
  input logic              xchg_sel_b,
  input logic [1:0]        xchg_ie_code,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              sel_a,
  input logic              sel_b,
  input logic              int_en,
  input logic              reserved_flag
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGS - 1);

  assert_sel_a_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |=> sel_a == $past(xchg_sel_a));

  assert_sel_b_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |=> sel_b == $past(xchg_sel_b));

  assert_ie_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && xchg_ie_code == 2'd2) |=> int_en);

  assert_ie_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && xchg_ie_code == 2'd3) |=> !int_en);

  assert_ie_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && !xchg_ie_code[1]) |=> $stable(int_en));

  assert_reserved_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && xchg_ie_code == 2'd1) |=> reserved_flag);

  assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(xchg_valid && xchg_ie_code == 2'd1) |=> !reserved_flag);

  assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_idx > LAST_IDX) |-> rd_a_data == '0) and ((rd_b_idx > LAST_IDX) |-> rd_b_data == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_valid |=> ($stable(sel_a) && $stable(sel_b) && $stable(int_en)));

endmodule

bind regbank_xchg regbank_xchg_chk #(.DATA_W(DATA_W), .REGS(REGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .xchg_valid(xchg_valid), .xchg_sel_a(xchg_sel_a),
  .xchg_sel_b(xchg_sel_b), .xchg_ie_code(xchg_ie_code), .rd_a_idx(rd_a_idx),
  .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .sel_a(sel_a), .sel_b(sel_b), .int_en(int_en), .reserved_flag(reserved_flag)
);

// File: tb/regbank_xchg_tb_top.sv
module regbank_xchg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xchg_valid = 1'b0, xchg_sel_a = 1'b0, xchg_sel_b = 1'b0;
  logic [1:0] xchg_ie_code = 2'd0;
  logic wr_en = 1'b0, wr_grp = 1'b0;
  logic [2:0] wr_idx = 3'd0, rd_a_idx = 3'd0, rd_b_idx = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_a_data, rd_b_data;
  logic sel_a, sel_b, int_en, reserved_flag;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [4][6];
  logic m_sa = 1'b0, m_sb = 1'b0, m_ie = 1'b0, m_res = 1'b0;

  always #5 clk = ~clk;

  regbank_xchg dut_i (
    .clk(clk), .rst_n(rst_n), .xchg_valid(xchg_valid), .xchg_sel_a(xchg_sel_a),
    .xchg_sel_b(xchg_sel_b), .xchg_ie_code(xchg_ie_code), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data), .rd_a_idx(rd_a_idx),
    .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .sel_a(sel_a), .sel_b(sel_b), .int_en(int_en), .reserved_flag(reserved_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic xv, input logic sa, input logic sb, input logic [1:0] code,
                      input logic we, input logic grp, input logic [2:0] idx, input logic [7:0] d);
    xchg_valid = xv; xchg_sel_a = sa; xchg_sel_b = sb; xchg_ie_code = code;
    wr_en = we; wr_grp = grp; wr_idx = idx; wr_data = d;
    @(posedge clk);
    if (we && idx < 3'd6) exp_mem[grp ? {1'b1, m_sb} : {1'b0, m_sa}][idx] = d;
    m_res = xv && code == 2'd1;
    if (xv) begin
      m_sa = sa; m_sb = sb;
      if (code == 2'd2) m_ie = 1'b1;
      if (code == 2'd3) m_ie = 1'b0;
    end
    @(negedge clk);
    xchg_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk(req, "sel_a", int'(sel_a), int'(m_sa));
    chk(req, "sel_b", int'(sel_b), int'(m_sb));
    chk(req, "int_en", int'(int_en), int'(m_ie));
    chk(req, "reserved_flag", int'(reserved_flag), int'(m_res));
  endtask

  task automatic check_reads(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_b_idx = 3'(i);
      #1;
      chk(req, $sformatf("rd_a[%0d]", i), int'(rd_a_data), i < 6 ? int'(exp_mem[{1'b0, m_sa}][i]) : 0);
      chk(req, $sformatf("rd_b[%0d]", i), int'(rd_b_data), i < 6 ? int'(exp_mem[{1'b1, m_sb}][i]) : 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 6; r++) exp_mem[b][r] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, all four banks read zero
    check_state("R1");
    for (int c = 0; c < 4; c++) begin
      step(1'b1, c[0], c[1], 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
      check_reads("R1");
    end
    step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);

    // R7 fill every bank through the active-bank routing
    for (int s = 0; s < 2; s++) begin
      step(1'b1, s[0], s[0], 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
      check_state("R2");
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 6; i++)
          step(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, g[0], 3'(i), 8'(g * 64 + s * 32 + i * 5 + 3));
      check_reads("R7");
    end

    // R2 R3 R6 every selector combination shows its bank, hidden banks retained
    for (int c = 0; c < 4; c++) begin
      step(1'b1, c[0], c[1], 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
      check_state("R3");
      check_reads("R6");
    end

    // R4 R5 every control code from both enable states
    for (int st = 0; st < 2; st++)
      for (int code = 0; code < 4; code++) begin
        step(1'b1, 1'b0, 1'b0, st[0] ? 2'd2 : 2'd3, 1'b0, 1'b0, 3'd0, 8'd0);
        step(1'b1, 1'b0, 1'b0, 2'(code), 1'b0, 1'b0, 3'd0, 8'd0);
        check_state(code == 1 ? "R5" : "R4");
        step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
        check_state("R5");
      end

    // R7 write in the same cycle as an exchange uses the old banks
    step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
    step(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 8'hEE);
    check_state("R7");
    check_reads("R7");
    step(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 3'd4, 8'hA5);
    check_reads("R7");
    step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
    check_reads("R7");

    // R8 out-of-range writes change nothing in any bank
    for (int c = 0; c < 4; c++) begin
      step(1'b1, c[0], c[1], 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
      for (int i = 6; i < 8; i++)
        for (int g = 0; g < 2; g++)
          step(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, g[0], 3'(i), 8'hFF);
    end
    for (int c = 0; c < 4; c++) begin
      step(1'b1, c[0], c[1], 2'd0, 1'b0, 1'b0, 3'd0, 8'd0);
      check_reads("R8");
    end

    // R9 idle cycles hold selectors and enable
    step(1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 3'd0, 8'd0);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 8'd0);
      check_state("R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule